// File: doc/BRIEF.md
# Machine Counter Block with Inhibit Control

This block holds the machine-level counters of a small RISC-V style core: a 64-bit cycle count, a 64-bit wall-clock (real-time) count and a 64-bit count of retired instructions. A two-bit inhibit register, set through the CSR port, can stop the cycle count and the retired-instruction count independently. The wall-clock count is never gated.

Software reaches all state through a CSR port. The port has a 12-bit address, a write enable, 32-bit write data and combinational read data. Each 64-bit counter appears as a low and a high 32-bit half. Two pulse inputs drive the counting: `tick` once per counted clock and `retire` once per retired instruction.

Top module: `ctr_inhibit_unit`

## Requirements
- R1: After reset, every counter and both inhibit bits read as zero, so counting is enabled.
- R2: A write to address 0x320 keeps only write-data bit 0 (cycle stop) and bit 2 (retire stop). A read of 0x320 returns those two bits in the same positions, with every other bit zero.
- R3: On a cycle with `tick` high and the cycle-stop bit clear, the cycle counter advances by one.
- R4: While the cycle-stop bit is set, the cycle counter holds its value. Counting resumes from that value once the bit is cleared.
- R5: The wall-clock counter advances by one on every `tick`, whatever the inhibit bits hold. It reads at 0xC01 (low) and 0xC81 (high), and writes to those addresses have no effect.
- R6: On a cycle with `retire` high, the retired-instruction counter advances by one if the retire-stop bit is clear and holds if it is set.
- R7: The cycle counter's halves are at 0xB00 (low) and 0xB80 (high). The retired-instruction counter's halves are at 0xB02 and 0xB82. A write replaces only the addressed half.
- R8: When a write to a counter half falls in the same cycle as that counter's increment, the written value is stored, the counter does not advance, and the other half is unchanged.
- R9: An inhibit write takes effect at the following tick. A tick in the same cycle as the inhibit write still uses the old setting.
- R10: A carry out of the low half of any counter propagates into its high half.
- R11: Reads of any unmapped address return zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 12 | CSR address for read and write |
| csr_we | input | 1 | CSR write enable |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | Combinational read data for csr_addr |
| tick | input | 1 | Count pulse for the cycle and wall-clock counters |
| retire | input | 1 | Instruction-retired pulse |

## Verification
The bench targets several corner cases:
- An inhibit write with a tick in the same cycle. A design that applied the new setting at once would lose or gain one count.
- A counter write that coincides with an increment. A design that added the increment after the write would read back one more than was written.
- Low-half wrap-around. Without the carry, the high half would stay stale.
- Writes to the wall-clock counter, to unmapped addresses and to the reserved inhibit bits. Any state that changed would show up as a mismatch on the next comparison.

// File: rtl/ctr_inhibit_unit.sv
`timescale 1ns/100ps
module ctr_inhibit_unit #(
  parameter int          XLEN     = 32,
  parameter logic [11:0] A_INH    = 12'h320,
  parameter logic [11:0] A_CYC_LO = 12'hB00,
  parameter logic [11:0] A_RET_LO = 12'hB02,
  parameter logic [11:0] A_CYC_HI = 12'hB80,
  parameter logic [11:0] A_RET_HI = 12'hB82,
  parameter logic [11:0] A_TIM_LO = 12'hC01,
  parameter logic [11:0] A_TIM_HI = 12'hC81
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [11:0]     csr_addr,
  input  logic            csr_we,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  input  logic            tick,
  input  logic            retire
);
  localparam int CW = 2 * XLEN;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic          cy_off, ir_off;
  logic [CW-1:0] cyc_q, tim_q, ret_q;

  wire wr_inh    = csr_we && (csr_addr == A_INH);
  wire wr_cyc_lo = csr_we && (csr_addr == A_CYC_LO);
  wire wr_cyc_hi = csr_we && (csr_addr == A_CYC_HI);
  wire wr_ret_lo = csr_we && (csr_addr == A_RET_LO);
  wire wr_ret_hi = csr_we && (csr_addr == A_RET_HI);
  wire wr_cyc    = wr_cyc_lo || wr_cyc_hi;
  wire wr_ret    = wr_ret_lo || wr_ret_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cy_off <= 1'b0;
      ir_off <= 1'b0;
      cyc_q  <= '0;
      tim_q  <= '0;
      ret_q  <= '0;
    end else begin
      if (wr_inh) begin
        cy_off <= csr_wdata[0];
        ir_off <= csr_wdata[2];
      end
      if (wr_cyc_lo)             cyc_q[XLEN-1:0]  <= csr_wdata;
      else if (wr_cyc_hi)        cyc_q[CW-1:XLEN] <= csr_wdata;
      else if (tick && !cy_off)  cyc_q <= cyc_q + ONE;
      if (wr_ret_lo)             ret_q[XLEN-1:0]  <= csr_wdata;
      else if (wr_ret_hi)        ret_q[CW-1:XLEN] <= csr_wdata;
      else if (retire && !ir_off) ret_q <= ret_q + ONE;
      if (tick) tim_q <= tim_q + ONE;
    end
  end

  always_comb begin
    csr_rdata = '0;
    case (csr_addr)
      A_INH:    csr_rdata = XLEN'({ir_off, 1'b0, cy_off});
      A_CYC_LO: csr_rdata = cyc_q[XLEN-1:0];
      A_CYC_HI: csr_rdata = cyc_q[CW-1:XLEN];
      A_RET_LO: csr_rdata = ret_q[XLEN-1:0];
      A_RET_HI: csr_rdata = ret_q[CW-1:XLEN];
      A_TIM_LO: csr_rdata = tim_q[XLEN-1:0];
      A_TIM_HI: csr_rdata = tim_q[CW-1:XLEN];
      default:  csr_rdata = '0;
    endcase
  end

  // R2
  inh_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == A_INH) |-> ((csr_rdata & ~XLEN'(5)) == '0));

  // R3
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cy_off && !wr_cyc) |=> (cyc_q == $past(cyc_q) + ONE));

  // R4
  cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cy_off && !wr_cyc) |=> $stable(cyc_q));

  // R5
  tim_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (tim_q == $past(tim_q) + ONE));

  // R5
  tim_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tim_q));

  // R6
  ret_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_off && !wr_ret) |=> $stable(ret_q));

  // R8
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cyc_lo |=> ((cyc_q[XLEN-1:0] == $past(csr_wdata)) &&
                   (cyc_q[CW-1:XLEN] == $past(cyc_q[CW-1:XLEN]))));
endmodule

// File: tb/ctr_inhibit_unit_tb.sv
`timescale 1ns/100ps
module ctr_inhibit_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick = 1'b0;
  logic        retire = 1'b0;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [63:0] m_cyc = '0, m_tim = '0, m_ret = '0;
  logic [2:0]  m_inh = '0;

  always #2 clk = ~clk;

  ctr_inhibit_unit u_dut (
    .clk(clk), .rst_n(rst_n), .csr_addr(addr), .csr_we(we),
    .csr_wdata(wdata), .csr_rdata(rdata), .tick(tick), .retire(retire));

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #0.1;
    tests++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, exp);
    end
  endtask

  task automatic compare_all();
    rd(12'h320, {29'b0, m_inh[2], 1'b0, m_inh[0]}, "R2");
    rd(12'hB00, m_cyc[31:0],  "R3");
    rd(12'hB80, m_cyc[63:32], "R10");
    rd(12'hB02, m_ret[31:0],  "R6");
    rd(12'hB82, m_ret[63:32], "R7");
    rd(12'hC01, m_tim[31:0],  "R5");
    rd(12'hC81, m_tim[63:32], "R5");
    rd(12'h123, 32'h0,        "R11");
  endtask

  task automatic step(input logic [11:0] a, input logic w, input logic [31:0] d,
                      input logic t, input logic r);
    addr = a; we = w; wdata = d; tick = t; retire = r;
    @(posedge clk);
    #0.2;
    we = 1'b0; tick = 1'b0; retire = 1'b0;
    if (w && a == 12'hB00)      m_cyc[31:0]  = d;
    else if (w && a == 12'hB80) m_cyc[63:32] = d;
    else if (t && !m_inh[0])    m_cyc = m_cyc + 64'd1;
    if (w && a == 12'hB02)      m_ret[31:0]  = d;
    else if (w && a == 12'hB82) m_ret[63:32] = d;
    else if (r && !m_inh[2])    m_ret = m_ret + 64'd1;
    if (t) m_tim = m_tim + 64'd1;
    if (w && a == 12'h320) m_inh = {d[2], 1'b0, d[0]};
    compare_all();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    logic [11:0] amap [8];
    logic [31:0] keep;
    amap = '{12'h320, 12'hB00, 12'hB80, 12'hB02, 12'hB82, 12'hC01, 12'hC81, 12'h123};
    lfsr = 32'hACE1_2345;
    repeat (3) @(posedge clk);
    #0.2 rst_n = 1'b1;
    // R1: reset state
    rd(12'hB00, 32'h0, "R1"); rd(12'hC01, 32'h0, "R1");
    rd(12'hB02, 32'h0, "R1"); rd(12'h320, 32'h0, "R1");
    compare_all();

    // R3 R5 R6: free counting
    for (int i = 0; i < 10; i++) step(12'h0, 1'b0, 32'h0, 1'b1, i[0]);
    rd(12'hB00, 32'd10, "R3");
    rd(12'hB02, 32'd5, "R6");

    // R2: all-ones inhibit write keeps bits 0 and 2
    // R9: tick in the same cycle still counts
    step(12'h320, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b1);
    rd(12'h320, 32'h5, "R2");
    rd(12'hB00, 32'd11, "R9");
    rd(12'hB02, 32'd6, "R9");
    keep = 32'd11;
    // R4 R5: stopped cycle counter while the wall clock runs
    for (int i = 0; i < 6; i++) step(12'h0, 1'b0, 32'h0, 1'b1, 1'b1);
    rd(12'hB00, keep, "R4");
    rd(12'hC01, 32'd17, "R5");
    rd(12'hB02, 32'd6, "R6");
    // R9: clearing the bits with a tick in the same cycle still holds
    step(12'h320, 1'b1, 32'h0000_0002, 1'b1, 1'b1);
    rd(12'hB00, keep, "R9");
    rd(12'h320, 32'h0, "R2");
    step(12'h0, 1'b0, 32'h0, 1'b1, 1'b0);
    rd(12'hB00, keep + 1, "R4");

    // R7 R8 R10: write priority and carry
    step(12'hB00, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0);
    rd(12'hB00, 32'hFFFF_FFFF, "R8");
    rd(12'hB80, 32'h0, "R8");
    step(12'h0, 1'b0, 32'h0, 1'b1, 1'b0);
    rd(12'hB00, 32'h0, "R10");
    rd(12'hB80, 32'h1, "R10");
    step(12'hB82, 1'b1, 32'h1234_5678, 1'b0, 1'b1);
    rd(12'hB82, 32'h1234_5678, "R8");
    rd(12'hB02, 32'd6, "R7");
    step(12'hB02, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0);
    step(12'h0, 1'b0, 32'h0, 1'b0, 1'b1);
    rd(12'hB82, 32'h1234_5679, "R10");

    // R5 R11: ignored writes
    step(12'hC01, 1'b1, 32'hDEAD_BEEF, 1'b0, 1'b0);
    step(12'hC81, 1'b1, 32'hDEAD_BEEF, 1'b0, 1'b0);
    step(12'h123, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0);
    rd(12'h123, 32'h0, "R11");
    step(12'h320, 1'b1, 32'h0000_0004, 1'b0, 1'b0);
    step(12'h0, 1'b0, 32'h0, 1'b1, 1'b1);
    rd(12'h320, 32'h4, "R2");

    // mixed traffic against the reference model
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(amap[lfsr[2:0]], lfsr[9:7] == 3'b0, {lfsr[15:0], lfsr[31:16]},
           lfsr[4], lfsr[5]);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule